// File: doc/BRIEF.md
# DSP Address Generation Unit

This block computes memory addresses for a signal-processing datapath without using the main arithmetic units. It holds a small bank of address pointers. Each pointer has its own pair of window bounds, a lower and an upper limit. Every cycle it can take one request. The request names a pointer, a modification mode, a step, a direction and whether the change applies before or after the access. The effective address comes back combinationally in the same cycle. The pointer is rewritten at the next clock edge, so walking a buffer costs no extra instruction and no extra cycle.

Three modification modes exist. Linear mode adds or subtracts the step modulo the address width. Circular mode keeps the pointer inside its window and wraps at either bound, so a delay line or filter history needs no software bounds test. Bit-reverse mode propagates the carry from the most significant bit downwards. With a step of half the transform size, a pointer on an aligned base visits the samples of a radix-2 FFT in reordered sequence. A separate write port loads pointers and window bounds.

Top module: `dsp_agu`

## Requirements
- R1: After synchronous reset every pointer, lower bound and upper bound reads as zero.
- R2: A request with `req_pre`=0 (post-modify) returns the unmodified pointer on `ea` in the same cycle. In linear mode (`req_mode` 0 or 3), the pointer becomes pointer plus step modulo 2^16 at the next edge.
- R3: A request with `req_pre`=1 (pre-modify) returns the modified value on `ea` in the same cycle and stores that same value into the pointer.
- R4: `req_dec`=1 subtracts the step instead of adding it. In linear mode the difference wraps modulo 2^16.
- R5: Circular mode (`req_mode`=1) with `req_dec`=0 gives lower + ((pointer − lower + step) mod L), where L = upper − lower + 1. Stepping past the upper bound therefore continues from the lower bound.
- R6: Circular mode with `req_dec`=1 gives lower + ((pointer − lower − step) mod L). Stepping below the lower bound continues from the upper bound downward.
- R7: In circular mode a step of L or more is first reduced modulo L.
- R8: Bit-reverse mode (`req_mode`=2) adds the step with the carry running from bit 15 toward bit 0. Carry out of bit 0 is dropped. With step 4 from an 8-aligned base B, the post-modify addresses are B+0,4,2,6,1,5,3,7 and then B again.
- R9: Bit-reverse mode with `req_dec`=1 subtracts with the borrow running from bit 15 toward bit 0. With step 4 from base B the sequence is B+0,7,3,5.
- R10: A write to a pointer (`wr_kind`=0) in the same cycle as a request on that same pointer stores the written value and discards the modification. A write to a different pointer does not block the request.
- R11: In a cycle with neither a request nor a write, no pointer or bound changes. `wr_kind` 1 selects the lower bound, 2 the upper bound, and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request this cycle |
| req_sel | input | 2 | Pointer index of the request |
| req_mode | input | 2 | 0/3 linear, 1 circular, 2 bit-reverse |
| req_pre | input | 1 | 1 modify before use, 0 after use |
| req_dec | input | 1 | 1 subtract step, 0 add step |
| req_step | input | 16 | Modification amount |
| wr_en | input | 1 | Register write this cycle |
| wr_sel | input | 2 | Pointer index of the write |
| wr_kind | input | 2 | 0 pointer, 1 lower bound, 2 upper bound, 3 none |
| wr_data | input | 16 | Value written |
| ea | output | 16 | Effective address of the current request |

## Verification
Linear requests are tried with increment and decrement, with pre- and post-modify, and across the zero boundary. These runs separate the two timing options and show that the wrap is modulo 2^16. Circular requests start near both bounds of an 8-word window and use steps of 1, 2 and 3 and steps larger than the window. They show which bound a wrap lands on and whether the step is reduced first. A full bit-reverse pass in both directions from an aligned base shows that the carry runs in the right direction and that the base bits are untouched. Same-cycle write and request pairs, on the same pointer and on different pointers, show the priority rule.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        AGU_LINEAR  = 2'd0,
        AGU_CIRC    = 2'd1,
        AGU_BITREV  = 2'd2,
        AGU_LINEAR2 = 2'd3
    } agu_mode_e;

    typedef enum logic [1:0] {
        WK_PTR   = 2'd0,
        WK_LOWER = 2'd1,
        WK_UPPER = 2'd2,
        WK_NONE  = 2'd3
    } agu_wkind_e;

    typedef struct packed {
        agu_mode_e mode;
        logic      pre;
        logic      dec;
    } agu_op_t;

endpackage

// File: rtl/agu_regs.sv
module agu_regs
    import agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_sel,
    input  agu_wkind_e          wr_kind,
    input  logic [AW-1:0]       wr_data,
    input  logic                upd_en,
    input  logic [SW-1:0]       upd_sel,
    input  logic [AW-1:0]       upd_data,
    output logic [NREG*AW-1:0]  ptr_flat,
    output logic [NREG*AW-1:0]  lo_flat,
    output logic [NREG*AW-1:0]  hi_flat
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [AW-1:0] ptr_q, lo_q, hi_q;
        logic          wr_hit;

        assign wr_hit = wr_en && (wr_sel == SW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
                lo_q  <= '0;
                hi_q  <= '0;
            end else begin
                // Write port has priority over the modify writeback
                if (wr_hit && wr_kind == WK_PTR)
                    ptr_q <= wr_data;
                else if (upd_en && upd_sel == SW'(i))
                    ptr_q <= upd_data;
                if (wr_hit && wr_kind == WK_LOWER)
                    lo_q <= wr_data;
                if (wr_hit && wr_kind == WK_UPPER)
                    hi_q <= wr_data;
            end
        end

        assign ptr_flat[i*AW +: AW] = ptr_q;
        assign lo_flat[i*AW +: AW]  = lo_q;
        assign hi_flat[i*AW +: AW]  = hi_q;
    end

endmodule

// File: rtl/agu_modify.sv
module agu_modify
    import agu_pkg::*;
#(
    parameter int AW  = 16,
    localparam int LW = AW + 1
) (
    input  agu_op_t        op,
    input  logic [AW-1:0]  cur,
    input  logic [AW-1:0]  lower,
    input  logic [AW-1:0]  upper,
    input  logic [AW-1:0]  step,
    output logic [AW-1:0]  nxt
);

    // Linear
    logic [AW-1:0] lin_nxt;
    assign lin_nxt = op.dec ? (cur - step) : (cur + step);

    // Circular: offset arithmetic inside the window
    logic [LW-1:0] win_len, len_safe, step_red, offs, offs_new;
    logic [AW-1:0] circ_nxt;

    always_comb begin
        win_len  = {1'b0, upper} - {1'b0, lower} + LW'(1);
        len_safe = (win_len == '0) ? LW'(1) : win_len;
        step_red = {1'b0, step} % len_safe;
        offs     = {1'b0, cur} - {1'b0, lower};
        if (op.dec) begin
            if (offs >= step_red) offs_new = offs - step_red;
            else                  offs_new = offs + len_safe - step_red;
        end else begin
            offs_new = offs + step_red;
            if (offs_new >= len_safe) offs_new = offs_new - len_safe;
        end
        circ_nxt = lower + offs_new[AW-1:0];
    end

    // Bit-reverse: carry runs from MSB toward LSB
    logic [AW-1:0] cur_rev, step_rev, sum_rev, brev_nxt;
    for (genvar b = 0; b < AW; b++) begin : g_rev
        assign cur_rev[b]  = cur[AW-1-b];
        assign step_rev[b] = step[AW-1-b];
        assign brev_nxt[b] = sum_rev[AW-1-b];
    end
    assign sum_rev = op.dec ? (cur_rev - step_rev) : (cur_rev + step_rev);

    always_comb begin
        unique case (op.mode)
            AGU_CIRC:   nxt = circ_nxt;
            AGU_BITREV: nxt = brev_nxt;
            default:    nxt = lin_nxt;
        endcase
    end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
    import agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [SW-1:0]  req_sel,
    input  logic [1:0]     req_mode,
    input  logic           req_pre,
    input  logic           req_dec,
    input  logic [AW-1:0]  req_step,
    input  logic           wr_en,
    input  logic [SW-1:0]  wr_sel,
    input  logic [1:0]     wr_kind,
    input  logic [AW-1:0]  wr_data,
    output logic [AW-1:0]  ea
);

    logic [NREG*AW-1:0] addr_flat, start_flat, end_flat;
    logic [AW-1:0]      cur, lower, upper, nxt;
    agu_op_t            op;

    assign op.mode = agu_mode_e'(req_mode);
    assign op.pre  = req_pre;
    assign op.dec  = req_dec;

    assign cur   = addr_flat[req_sel*AW +: AW];
    assign lower = start_flat[req_sel*AW +: AW];
    assign upper = end_flat[req_sel*AW +: AW];

    agu_modify #(.AW(AW)) u_mod (
        .op    (op),
        .cur   (cur),
        .lower (lower),
        .upper (upper),
        .step  (req_step),
        .nxt   (nxt)
    );

    assign ea = op.pre ? nxt : cur;

    agu_regs #(.AW(AW), .NREG(NREG)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_kind  (agu_wkind_e'(wr_kind)),
        .wr_data  (wr_data),
        .upd_en   (req_valid),
        .upd_sel  (req_sel),
        .upd_data (nxt),
        .ptr_flat (addr_flat),
        .lo_flat  (start_flat),
        .hi_flat  (end_flat)
    );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [SW-1:0]      req_sel,
    input logic [1:0]         req_mode,
    input logic               req_pre,
    input logic               req_dec,
    input logic [AW-1:0]      req_step,
    input logic               wr_en,
    input logic [SW-1:0]      wr_sel,
    input logic [1:0]         wr_kind,
    input logic [AW-1:0]      wr_data,
    input logic [AW-1:0]      ea,
    input logic [NREG*AW-1:0] addr_flat,
    input logic [NREG*AW-1:0] start_flat,
    input logic [NREG*AW-1:0] end_flat
);

    logic [SW-1:0] rsel_q, wsel_q;
    logic [AW-1:0] cur_a, cur_s, cur_e, now_a, now_s, now_e, wnow_a;
    logic          same_wr;

    always_ff @(posedge clk) begin
        rsel_q <= req_sel;
        wsel_q <= wr_sel;
    end

    always_comb begin
        cur_a   = addr_flat[req_sel*AW +: AW];
        cur_s   = start_flat[req_sel*AW +: AW];
        cur_e   = end_flat[req_sel*AW +: AW];
        now_a   = addr_flat[rsel_q*AW +: AW];
        now_s   = start_flat[rsel_q*AW +: AW];
        now_e   = end_flat[rsel_q*AW +: AW];
        wnow_a  = addr_flat[wsel_q*AW +: AW];
        same_wr = wr_en && wr_kind == 2'd0 && wr_sel == req_sel;
    end

    p_post_linear_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !same_wr && req_mode == 2'd0 && !req_pre && !req_dec
        |=> now_a == $past(ea) + $past(req_step));

    p_pre_ea_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !same_wr && req_pre |=> now_a == $past(ea));

    p_circ_window_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid && !wr_en && req_mode == 2'd1 &&
        cur_s <= cur_a && cur_a <= cur_e
        |=> now_s <= now_a && now_a <= now_e);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_kind == 2'd0 |=> wnow_a == $past(wr_data));

    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid && !wr_en
        |=> $stable(addr_flat) && $stable(start_flat) && $stable(end_flat));

endmodule

bind dsp_agu agu_checker #(.AW(AW), .NREG(NREG)) u_chk (.*);

// File: tb/dsp_agu_tb.sv
module dsp_agu_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_pre, req_dec, wr_en;
    logic [1:0]  req_sel, req_mode, wr_sel, wr_kind;
    logic [15:0] req_step, wr_data, ea;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dsp_agu u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_mode(req_mode), .req_pre(req_pre), .req_dec(req_dec),
        .req_step(req_step), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_kind(wr_kind), .wr_data(wr_data), .ea(ea)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cycle(input logic rv, input logic [1:0] s, input logic [1:0] m,
                         input logic p, input logic d, input logic [15:0] st,
                         input logic we, input logic [1:0] ws, input logic [1:0] wk,
                         input logic [15:0] wd, output logic [15:0] e);
        @(negedge clk);
        req_valid = rv; req_sel = s; req_mode = m; req_pre = p; req_dec = d;
        req_step = st; wr_en = we; wr_sel = ws; wr_kind = wk; wr_data = wd;
        #1 e = ea;
        @(posedge clk);
        #1 req_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [1:0] k, input logic [15:0] d);
        logic [15:0] e;
        cycle(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 16'd0, 1'b1, s, k, d, e);
    endtask

    task automatic rq(input logic [1:0] s, input logic [1:0] m, input logic p,
                      input logic d, input logic [15:0] st, output logic [15:0] e);
        cycle(1'b1, s, m, p, d, st, 1'b0, 2'd0, 2'd3, 16'd0, e);
    endtask

    task automatic peek(input logic [1:0] s, output logic [15:0] e);
        rq(s, 2'd0, 1'b0, 1'b0, 16'd0, e);
    endtask

    task automatic t_reset;
        logic [15:0] e;
        for (int i = 0; i < 4; i++) begin
            peek(2'(i), e);
            check("R1 pointer zero", e, 16'h0);
        end
        // zero bounds give a window of one word: pointer must stay zero
        rq(2'd0, 2'd1, 1'b1, 1'b0, 16'd5, e);
        check("R1 bounds zero", e, 16'h0);
    endtask

    task automatic t_linear;
        logic [15:0] e;
        wr(2'd1, 2'd0, 16'h1000);
        rq(2'd1, 2'd0, 1'b0, 1'b0, 16'd3, e);
        check("R2 post ea", e, 16'h1000);
        peek(2'd1, e);
        check("R2 post update", e, 16'h1003);
        rq(2'd1, 2'd3, 1'b0, 1'b1, 16'd5, e);
        check("R4 dec ea", e, 16'h1003);
        peek(2'd1, e);
        check("R4 dec update", e, 16'h0FFE);
        rq(2'd1, 2'd0, 1'b1, 1'b0, 16'd2, e);
        check("R3 pre ea", e, 16'h1000);
        peek(2'd1, e);
        check("R3 pre update", e, 16'h1000);
        wr(2'd1, 2'd0, 16'h0000);
        rq(2'd1, 2'd0, 1'b1, 1'b1, 16'd1, e);
        check("R4 wrap below zero", e, 16'hFFFF);
    endtask

    task automatic t_circular;
        logic [15:0] e;
        wr(2'd2, 2'd1, 16'h0020);
        wr(2'd2, 2'd2, 16'h0027);
        wr(2'd2, 2'd0, 16'h0026);
        rq(2'd2, 2'd1, 1'b0, 1'b0, 16'd1, e);
        check("R5 post ea", e, 16'h0026);
        rq(2'd2, 2'd1, 1'b0, 1'b0, 16'd1, e);
        check("R5 at upper", e, 16'h0027);
        peek(2'd2, e);
        check("R5 wrap to lower", e, 16'h0020);
        wr(2'd2, 2'd0, 16'h0026);
        rq(2'd2, 2'd1, 1'b1, 1'b0, 16'd3, e);
        check("R5 wrap by 3", e, 16'h0021);
        rq(2'd2, 2'd1, 1'b1, 1'b1, 16'd2, e);
        check("R6 wrap below lower", e, 16'h0027);
        wr(2'd2, 2'd0, 16'h0020);
        rq(2'd2, 2'd1, 1'b1, 1'b0, 16'd19, e);
        check("R7 large step inc", e, 16'h0023);
        rq(2'd2, 2'd1, 1'b1, 1'b1, 16'd17, e);
        check("R7 large step dec", e, 16'h0022);
    endtask

    task automatic t_bitrev;
        logic [15:0] e;
        logic [15:0] ord_inc [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        logic [15:0] ord_dec [4] = '{0, 7, 3, 5};
        wr(2'd3, 2'd0, 16'h0100);
        for (int i = 0; i < 8; i++) begin
            rq(2'd3, 2'd2, 1'b0, 1'b0, 16'd4, e);
            check("R8 reversed order", e, 16'h0100 + ord_inc[i]);
        end
        peek(2'd3, e);
        check("R8 back to base", e, 16'h0100);
        for (int i = 0; i < 4; i++) begin
            rq(2'd3, 2'd2, 1'b0, 1'b1, 16'd4, e);
            check("R9 reversed borrow", e, 16'h0100 + ord_dec[i]);
        end
        peek(2'd3, e);
        check("R9 next after sequence", e, 16'h0101);
    endtask

    task automatic t_priority;
        logic [15:0] e;
        wr(2'd1, 2'd0, 16'h0010);
        cycle(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 16'd7, 1'b1, 2'd1, 2'd0, 16'h5555, e);
        peek(2'd1, e);
        check("R10 write beats modify", e, 16'h5555);
        cycle(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 16'd1, 1'b1, 2'd0, 2'd0, 16'hAAAA, e);
        peek(2'd0, e);
        check("R10 other write lands", e, 16'hAAAA);
        peek(2'd1, e);
        check("R10 other modify lands", e, 16'h5556);
    endtask

    task automatic t_idle;
        logic [15:0] e;
        logic [15:0] exp_ptr [4] = '{16'hAAAA, 16'h5556, 16'h0022, 16'h0101};
        repeat (6) @(posedge clk);
        // a write with kind 3 must not alter anything
        wr(2'd2, 2'd3, 16'hDEAD);
        for (int i = 0; i < 4; i++) begin
            peek(2'(i), e);
            check("R11 idle keeps pointer", e, exp_ptr[i]);
        end
        rq(2'd2, 2'd1, 1'b1, 1'b0, 16'd6, e);
        check("R11 bounds kept", e, 16'h0020);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_sel = '0; req_mode = '0; req_pre = 1'b0;
        req_dec = 1'b0; req_step = '0; wr_en = 1'b0; wr_sel = '0;
        wr_kind = 2'd3; wr_data = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_linear;
        t_circular;
        t_bitrev;
        t_priority;
        t_idle;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule